// File: doc/BRIEF.md
# Receive Frame Part Segmenter

This block sits on the receive side of a frame interface and works out where each incoming byte lands in host memory. Memory is handed out in fixed-size pages drawn from a pool of free page numbers. The block keeps filling the current page until it is full, then takes the next free page. Successive pages need not be adjacent. A frame is therefore stored as one or more parts, and no part ever crosses a page boundary.

For each part the block emits a two-word descriptor. The descriptor gives the page number, the byte offset where the part starts, its length in bytes, and a tag that says where the part sits within its frame. The descriptor that closes a frame also carries the frame's error flag.

A new frame continues in the current page when space is left, so short frames pack tightly. If the pool is empty at the moment a page is needed, the byte input is held off until a page arrives.

Top module: `rx_part_segmenter`

## Requirements
- R1: After reset no address and no descriptor is produced. The first accepted byte always takes a fresh page from the pool.
- R2: Each accepted byte is reported in the same cycle on `addr`, which is equal to {page number, offset}. Offsets within a page increase by one per accepted byte.
- R3: A part lies wholly inside one page. Its byte count is at least 1 and at most 2^PAGE_W. A part closes on the byte at the last offset of its page, or on the frame's final byte, whichever comes first.
- R4: A frame held in a single part yields exactly one descriptor, tagged Only (tag 00).
- R5: A frame spanning several parts yields, in order, one First descriptor (tag 01), zero or more Middle descriptors (tag 10) and one Last descriptor (tag 11).
- R6: `pg_ready` pulses, together with the accepted byte, exactly when that byte is placed at offset 0 of a page taken from the pool. The page number used is the one offered on `pg_num`, whatever its value.
- R7: When a page is needed and `pg_valid` is low, `in_ready` is low and no byte address is produced. Once a page is offered, the stalled byte is accepted.
- R8: A frame that starts while the current page has free space begins at the next free offset of that page. A frame that starts after a page was filled exactly begins at offset 0 of a new page.
- R9: Descriptor word 0 carries the tag in bits [31:30], the status in bit [29], zeros in bits [28:PAGE_W+1] and the byte count in bits [PAGE_W:0]. Word 1 carries the page number in bits [31:PAGE_W] and the start offset in bits [PAGE_W-1:0].
- R10: The status bit equals `in_err` sampled with the frame's final byte on Only and Last descriptors, and is 0 on First and Middle descriptors.
- R11: `desc_valid` is high for exactly the one cycle that follows the acceptance of the byte closing a part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is offered |
| in_sof | input | 1 | Offered byte is the first of a frame |
| in_eof | input | 1 | Offered byte is the last of a frame |
| in_err | input | 1 | Frame error flag, meaningful with `in_eof` |
| in_ready | output | 1 | Byte can be accepted this cycle |
| pg_valid | input | 1 | A free page number is offered |
| pg_num | input | PGN_W | Offered free page number |
| pg_ready | output | 1 | Offered page is consumed this cycle |
| addr_valid | output | 1 | A byte is accepted this cycle |
| addr | output | 32 | Memory byte address of the accepted byte |
| desc_valid | output | 1 | Descriptor words are valid |
| desc_w0 | output | 32 | Descriptor word 0: tag, status, count |
| desc_w1 | output | 32 | Descriptor word 1: page, offset |

## Verification
The bench builds the block with PAGE_W=4 and PGN_W=28, so a page holds 16 bytes. With pages this small, frames of a few dozen bytes produce First, several Middle and Last parts. They also reach a frame that ends exactly on a page's last byte, a frame that exactly fills a whole page, and a one-byte frame sitting at the final offset. Out-of-order page numbers and a deliberately withheld pool exercise the page handover and the stall path.

// File: rtl/rx_part_segmenter.sv
module rx_part_segmenter #(
  parameter int PAGE_W = 12,
  parameter int PGN_W  = 32 - PAGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_err,
  output logic             in_ready,
  input  logic             pg_valid,
  input  logic [PGN_W-1:0] pg_num,
  output logic             pg_ready,
  output logic             addr_valid,
  output logic [31:0]      addr,
  output logic             desc_valid,
  output logic [31:0]      desc_w0,
  output logic [31:0]      desc_w1
);
  localparam int LEN_W = PAGE_W + 1;
  localparam int PAD_W = 29 - LEN_W;

  logic              have;
  logic [PGN_W-1:0]  page;
  logic [LEN_W-1:0]  off;
  logic [PAGE_W-1:0] start;
  logic [LEN_W-1:0]  len;
  logic              first;

  logic              need, take, fresh, close, p_first;
  logic [PGN_W-1:0]  e_page;
  logic [PAGE_W-1:0] e_off, p_start;
  logic [LEN_W-1:0]  p_len;
  logic [1:0]        tag;

  assign need     = !have || off[PAGE_W];
  assign in_ready = !need || pg_valid;
  assign take     = in_valid && in_ready;
  assign pg_ready = take && need;

  assign e_page  = need ? pg_num : page;
  assign e_off   = need ? '0 : off[PAGE_W-1:0];
  assign fresh   = in_sof || (len == '0);
  assign p_start = fresh ? e_off : start;
  assign p_len   = (in_sof ? '0 : len) + LEN_W'(1);
  assign p_first = in_sof || first;
  assign close   = in_eof || (&e_off);
  assign tag     = in_eof ? (p_first ? 2'b00 : 2'b11) : (p_first ? 2'b01 : 2'b10);

  assign addr_valid = take;
  assign addr       = {e_page, e_off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have       <= 1'b0;
      page       <= '0;
      off        <= '0;
      start      <= '0;
      len        <= '0;
      first      <= 1'b1;
      desc_valid <= 1'b0;
      desc_w0    <= '0;
      desc_w1    <= '0;
    end else begin
      desc_valid <= take && close;
      if (take) begin
        have  <= 1'b1;
        page  <= e_page;
        off   <= {1'b0, e_off} + LEN_W'(1);
        start <= p_start;
        if (close) begin
          len     <= '0;
          first   <= in_eof;
          desc_w0 <= {tag, in_eof & in_err, {PAD_W{1'b0}}, p_len};
          desc_w1 <= {e_page, p_start};
        end else begin
          len   <= p_len;
          first <= p_first;
        end
      end
    end
  end
endmodule

module rx_part_segmenter_chk #(
  parameter int PAGE_W = 12,
  parameter int PGN_W  = 32 - PAGE_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eof,
  input logic             in_ready,
  input logic             pg_valid,
  input logic             pg_ready,
  input logic             addr_valid,
  input logic [31:0]      addr,
  input logic             desc_valid,
  input logic [31:0]      desc_w0,
  input logic [31:0]      desc_w1
);
  localparam int SZ = 1 << PAGE_W;
  logic [PAGE_W+1:0] cnt, endp;
  assign cnt  = {1'b0, desc_w0[PAGE_W:0]};
  assign endp = {2'b0, desc_w1[PAGE_W-1:0]} + cnt;

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |-> !addr_valid && !pg_ready && !pg_valid);
  assert_take_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pg_ready |-> pg_valid && addr_valid && (addr[PAGE_W-1:0] == '0));
  assert_desc_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> $past(addr_valid && (in_eof || (&addr[PAGE_W-1:0]))));
  assert_part_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> (cnt != '0) && (endp <= (PAGE_W+2)'(SZ)));
  assert_part_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_w1[31:PAGE_W] == $past(addr[31:PAGE_W]));
  assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_w0[28:PAGE_W+1] == '0);
  assert_mid_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && (desc_w0[31:30] == 2'b01 || desc_w0[31:30] == 2'b10) |-> !desc_w0[29]);
endmodule

bind rx_part_segmenter rx_part_segmenter_chk #(.PAGE_W(PAGE_W), .PGN_W(PGN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eof(in_eof), .in_ready(in_ready),
  .pg_valid(pg_valid), .pg_ready(pg_ready), .addr_valid(addr_valid), .addr(addr),
  .desc_valid(desc_valid), .desc_w0(desc_w0), .desc_w1(desc_w1)
);

// File: tb/tb_rx_part_segmenter.sv
`timescale 1ns/1ps
module tb_rx_part_segmenter;
  localparam int PW = 4;
  localparam int NW = 28;
  localparam int PS = 1 << PW;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0;
  logic pg_valid = 0;
  logic [NW-1:0] pg_num = '0;
  logic in_ready, pg_ready, addr_valid, desc_valid;
  logic [31:0] addr, desc_w0, desc_w1;

  rx_part_segmenter #(.PAGE_W(PW), .PGN_W(NW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_err(in_err), .in_ready(in_ready), .pg_valid(pg_valid), .pg_num(pg_num),
    .pg_ready(pg_ready), .addr_valid(addr_valid), .addr(addr), .desc_valid(desc_valid),
    .desc_w0(desc_w0), .desc_w1(desc_w1)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [NW-1:0] pool[$];
  int hold = 0;
  logic [63:0] exp_q[$];
  bit exp_dv = 0;

  bit m_have = 0, m_first = 1;
  logic [NW-1:0] m_page = '0;
  int m_off = 0, m_len = 0, m_start = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(bit sof, bit eof, bit err);
    bit accepted = 0;
    while (!accepted) begin
      bit need;
      @(negedge clk);
      in_valid = 1; in_sof = sof; in_eof = eof; in_err = err;
      pg_valid = (pool.size() > 0) && (hold == 0);
      pg_num   = (pool.size() > 0) ? pool[0] : '0;
      #1;
      need = !m_have || (m_off == PS);
      if (need && !pg_valid) begin
        chk(in_ready == 0, "R7 in_ready", {31'b0, in_ready}, 0);
        chk(addr_valid == 0, "R7 addr_valid", {31'b0, addr_valid}, 0);
        if (hold > 0) hold--;
      end else begin
        logic [NW-1:0] ep;
        int eo, flen, st;
        bit fst, cl;
        logic [1:0] tg;
        chk(in_ready == 1, "R7 accept", {31'b0, in_ready}, 1);
        chk(pg_ready == need, "R6 pg_ready", {31'b0, pg_ready}, {31'b0, need});
        ep = need ? pool[0] : m_page;
        eo = need ? 0 : m_off;
        chk(addr == {ep, eo[PW-1:0]}, "R2/R8 addr", addr, {ep, eo[PW-1:0]});
        flen = sof ? 1 : m_len + 1;
        st   = (sof || m_len == 0) ? eo : m_start;
        fst  = sof || m_first;
        cl   = eof || (eo == PS - 1);
        if (cl) begin
          tg = eof ? (fst ? 2'b00 : 2'b11) : (fst ? 2'b01 : 2'b10);
          exp_q.push_back({tg, eof & err, 24'b0, flen[PW:0], ep, st[PW-1:0]});
          exp_dv = 1;
          m_len = 0; m_first = eof;
        end else begin
          m_len = flen; m_first = fst;
        end
        m_start = st;
        m_have = 1; m_page = ep; m_off = eo + 1;
        if (need) void'(pool.pop_front());
        accepted = 1;
      end
    end
  endtask

  task automatic frame(int n, bit err);
    for (int i = 0; i < n; i++) send(i == 0, i == n - 1, err);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0; pg_valid = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(desc_valid == exp_dv, "R11 desc_valid timing", {31'b0, desc_valid}, {31'b0, exp_dv});
    exp_dv = 0;
    if (desc_valid) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected descriptor", desc_w0, 0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(desc_w0[31:30] == e[63:62], (e[63:62] == 2'b00) ? "R4 tag" : "R5 tag",
            {30'b0, desc_w0[31:30]}, {30'b0, e[63:62]});
        chk(desc_w0[29] == e[61], "R10 status", {31'b0, desc_w0[29]}, {31'b0, e[61]});
        chk(desc_w0[PW:0] == e[32+PW:32], "R3 byte count", desc_w0, e[63:32]);
        chk(desc_w0 == e[63:32] && desc_w1 == e[31:0], "R9 layout", desc_w1, e[31:0]);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R11 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    in_valid = 1; in_sof = 1;
    #1;
    chk(desc_valid == 0, "R1 desc after reset", {31'b0, desc_valid}, 0);
    chk(addr_valid == 0, "R1 addr with empty pool", {31'b0, addr_valid}, 0);
    chk(in_ready == 0, "R1 first byte needs a page", {31'b0, in_ready}, 0);
    idle(2);
    pool.push_back(28'h0000abc); pool.push_back(28'h0000012);
    pool.push_back(28'h0000777); pool.push_back(28'h0000300);
    pool.push_back(28'h0000055); pool.push_back(28'h00000a1);
    pool.push_back(28'h0000f00); pool.push_back(28'h0000003);
    hold = 3;
    frame(5, 0);           // R4 Only, R7 stall on first byte
    idle(2);
    frame(6, 1);           // R8 continue at offset 5, R10 status set
    frame(20, 0);          // R5 First then Last across pages
    idle(3);
    frame(40, 1);          // R5 First, Middle, Middle, Last
    frame(9, 0);           // R3 ends on last offset of page
    frame(16, 0);          // R8 fresh page, R3 full-page part
    frame(15, 1);
    frame(1, 1);           // single byte at last offset
    frame(1, 0);           // R6 fresh page again
    idle(4);
    chk(exp_q.size() == 0, "R11 pending descriptors", exp_q.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule